// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a small multi-cycle processor core whose only data register is an 8-bit accumulator. It reads 16-bit instruction words from a 256-word memory through one synchronous port. The same port reads operands and writes results. It executes immediate arithmetic and logic, loads from memory, add and subtract with a memory operand, two store forms and absolute jumps. Two of the jumps are conditional on whether the accumulator is zero.

Each instruction word carries a 4-bit opcode in bits 15:12 and an 8-bit constant or address in bits 7:0. The core spends three clocks on every instruction:
- It fetches the word at the program counter.
- It captures that word and issues the operand read.
- It executes the instruction, which may include a memory write.

A taken jump whose target is its own address means the program has finished. In that case the core raises a halt flag that stays set, and it freezes.

The memory sits outside the block and has one cycle of read latency. The accumulator, program counter, zero flag and halt flag are visible as outputs.

Top module: `acc_core`

## Requirements
- R1: Opcode sits in instruction bits 15:12 and the operand (constant or address) in bits 7:0. Bits 11:8 have no effect on any opcode except 1100.
- R2: Every instruction takes exactly three clocks (fetch, decode, execute) against a memory whose read data appears one clock after the address. An instruction at index k of a straight-line program completes at the 3(k+1)-th rising edge after reset release.
- R3: An asynchronous active-low reset immediately clears the program counter, accumulator, zero flag and halt flag.
- R4: MOVE (0000) loads the constant. ADD (0001), SUB (0010) and AND (0011) combine the accumulator with the constant. Arithmetic wraps modulo 256 (255+1=0, 246+255=245, 3-7=252).
- R5: LOAD (0100) copies bits 7:0 of the addressed word into the accumulator. ADDM (0110) and SUBM (0111) add or subtract those bits, modulo 256.
- R6: Every instruction that writes the accumulator (MOVE, ADD, SUB, AND, LOAD, ADDM, SUBM) sets the zero flag to 1 exactly when the new accumulator value is 0. Other instructions leave it unchanged.
- R7: STORE (0101) writes {8'h00, accumulator} to the addressed word and leaves the accumulator unchanged.
- R8: Opcode 1100 writes {bits 11:8 of the instruction, 4'h0, accumulator} to the addressed word. A nibble of 8 with an accumulator of 20 gives 16'h8014.
- R9: JUMPU (1000) always loads the PC with the address. JUMPZ (1001) loads it when the accumulator is zero, otherwise PC+1. JUMPNZ (1010) loads it when the accumulator is non-zero, otherwise PC+1.
- R10: Opcodes 1011, 1101, 1110 and 1111 change nothing except advancing the PC by one.
- R11: A taken jump whose target equals its own address sets a halt output that stays high until reset. From then on the PC and accumulator hold and no memory write occurs. A conditional jump to its own address that is not taken does not halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Word address for memory read or write |
| mem_we | output | 1 | Memory write strobe for the current cycle |
| mem_wdata | output | 16 | Word to write when mem_we is high |
| mem_rdata | input | 16 | Word at the address presented in the previous cycle |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 8 | Program counter |
| zero_o | output | 1 | Zero flag |
| halt_o | output | 1 | Sticky self-jump halt flag |

## Verification
The bench goes after wrap-around in both directions and after the zero flag following MOVE and LOAD. A core that only updated the flag on arithmetic would leave a stale flag there. It also checks that the upper byte of a memory operand is ignored, and that a store clears the upper bits of a word that was preloaded with all ones.

Jump chains mix taken and untaken branches, so a swapped condition lands on a different path. That shows up as a wrong accumulator and a wrong instruction count.

Reserved opcodes are given targets that would skip code if they were decoded as jumps. An untaken conditional jump to its own address must fall through rather than halt. After a halt, the bench watches the core for many cycles and requires that nothing moves and nothing is written.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int OPC_W  = 4;
  localparam int NIB_W  = WORD_W - OPC_W - DATA_W;

  localparam logic [OPC_W-1:0] OP_MOVE   = 4'h0;
  localparam logic [OPC_W-1:0] OP_ADD    = 4'h1;
  localparam logic [OPC_W-1:0] OP_SUB    = 4'h2;
  localparam logic [OPC_W-1:0] OP_AND    = 4'h3;
  localparam logic [OPC_W-1:0] OP_LOAD   = 4'h4;
  localparam logic [OPC_W-1:0] OP_STORE  = 4'h5;
  localparam logic [OPC_W-1:0] OP_ADDM   = 4'h6;
  localparam logic [OPC_W-1:0] OP_SUBM   = 4'h7;
  localparam logic [OPC_W-1:0] OP_JMP    = 4'h8;
  localparam logic [OPC_W-1:0] OP_JMPZ   = 4'h9;
  localparam logic [OPC_W-1:0] OP_JMPNZ  = 4'hA;
  localparam logic [OPC_W-1:0] OP_STNIB  = 4'hC;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } phase_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0]  op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_acc_o
);
  always_comb begin
    res_o    = acc_i;
    wr_acc_o = 1'b1;
    unique case (op_i)
      OP_MOVE: res_o = imm_i;
      OP_ADD:  res_o = acc_i + imm_i;
      OP_SUB:  res_o = acc_i - imm_i;
      OP_AND:  res_o = acc_i & imm_i;
      OP_LOAD: res_o = mem_i;
      OP_ADDM: res_o = acc_i + mem_i;
      OP_SUBM: res_o = acc_i - mem_i;
      default: wr_acc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              acc_zero_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              exec_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halt_o
);
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] ir_q;
  logic              halt_q, halt_d;
  logic              ir_en, pc_en, taken;
  logic [OPC_W-1:0]  op;
  logic [ADDR_W-1:0] target;

  assign op     = ir_q[WORD_W-1 -: OPC_W];
  assign target = ir_q[ADDR_W-1:0];
  assign ir_en  = (phase_q == ST_DECODE);
  assign pc_en  = (phase_q == ST_EXEC);

  always_comb begin
    unique case (op)
      OP_JMP:   taken = 1'b1;
      OP_JMPZ:  taken = acc_zero_i;
      OP_JMPNZ: taken = ~acc_zero_i;
      default:  taken = 1'b0;
    endcase
  end

  always_comb begin
    phase_d    = phase_q;
    pc_d       = pc_q;
    halt_d     = halt_q;
    mem_addr_o = pc_q;
    unique case (phase_q)
      ST_FETCH:  phase_d = ST_DECODE;
      ST_DECODE: begin
        mem_addr_o = mem_rdata_i[ADDR_W-1:0];
        phase_d    = ST_EXEC;
      end
      ST_EXEC: begin
        mem_addr_o = target;
        pc_d       = taken ? target : pc_q + ADDR_W'(1);
        if (taken && (target == pc_q)) begin
          halt_d  = 1'b1;
          phase_d = ST_HALT;
        end else begin
          phase_d = ST_FETCH;
        end
      end
      default: phase_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      halt_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      halt_q  <= halt_d;
      if (ir_en) ir_q <= mem_rdata_i;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign exec_o = (phase_q == ST_EXEC);
  assign ir_o   = ir_q;
  assign pc_o   = pc_q;
  assign halt_o = halt_q;

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == ST_FETCH |=> phase_q == ST_DECODE);
  // R2
  decode_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == ST_DECODE |=> phase_q == ST_EXEC);
  // R2
  pc_only_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != ST_EXEC |=> $stable(pc_q));
  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q);
  // R11
  halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(pc_q));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [7:0]  mem_addr,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic [7:0]  acc_o,
  output logic [7:0]  pc_o,
  output logic        zero_o,
  output logic        halt_o
);
  logic [WORD_W-1:0] ir;
  logic              exec;
  logic [DATA_W-1:0] acc_q, acc_d, alu_res;
  logic              zero_q, zero_d, alu_wr, acc_en;
  logic [OPC_W-1:0]  op;

  assign op = ir[WORD_W-1 -: OPC_W];

  acc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rdata_i (mem_rdata),
    .acc_zero_i  (acc_q == '0),
    .mem_addr_o  (mem_addr),
    .exec_o      (exec),
    .ir_o        (ir),
    .pc_o        (pc_o),
    .halt_o      (halt_o)
  );

  acc_alu u_alu (
    .op_i     (op),
    .acc_i    (acc_q),
    .imm_i    (ir[DATA_W-1:0]),
    .mem_i    (mem_rdata[DATA_W-1:0]),
    .res_o    (alu_res),
    .wr_acc_o (alu_wr)
  );

  assign acc_en = exec & alu_wr;

  always_comb begin
    acc_d  = alu_res;
    zero_d = (alu_res == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      zero_q <= zero_d;
    end
  end

  always_comb begin
    mem_we    = exec & ((op == OP_STORE) | (op == OP_STNIB));
    mem_wdata = {{(WORD_W-DATA_W){1'b0}}, acc_q};
    if (op == OP_STNIB)
      mem_wdata = {ir[DATA_W +: NIB_W], {(WORD_W-NIB_W-DATA_W){1'b0}}, acc_q};
  end

  assign acc_o  = acc_q;
  assign zero_o = zero_q;

  // R6
  zero_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> zero_q == (acc_q == '0));
  // R4
  acc_hold_outside_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(acc_q));
  // R11
  no_write_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !mem_we);
  // R7
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(acc_q));
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [7:0]  acc_o, pc_o;
  logic        zero_o, halt_o;

  logic [15:0] mem [256];
  logic        ld_en = 1'b0, clr_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_o(acc_o),
    .pc_o(pc_o), .zero_o(zero_o), .halt_o(halt_o)
  );

  always @(posedge clk) begin
    if (clr_en) begin
      for (int i = 0; i < 256; i++) mem[i] <= ld_data;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic [3:0] op, logic [3:0] nib, logic [7:0] opd);
    return {op, nib, opd};
  endfunction

  task automatic fill(logic [15:0] v);
    ld_data = v; clr_en = 1'b1; @(negedge clk); clr_en = 1'b0;
  endtask

  task automatic poke(logic [7:0] a, logic [15:0] d);
    ld_addr = a; ld_data = d; ld_en = 1'b1; @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0; @(negedge clk); fill(16'h0000);
  endtask

  // release reset, count cycles until halt is seen
  task automatic run(output int cycles);
    cycles = 0;
    rst_n = 1'b1;
    while (!halt_o && cycles < 600) begin
      @(negedge clk); cycles++;
    end
  endtask

  task automatic t_reset();
    int c;
    hold_reset();
    chk("R3", "pc in reset", 16'(pc_o), 16'h0);
    chk("R3", "acc in reset", 16'(acc_o), 16'h0);
    chk("R3", "flags in reset", {14'h0, zero_o, halt_o}, 16'h0);
    poke(8'd0, enc(4'h0, 4'h0, 8'd5));
    poke(8'd1, enc(4'h1, 4'h0, 8'd1));
    poke(8'd2, enc(4'h8, 4'h0, 8'd1));
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R3", "async pc clear", 16'(pc_o), 16'h0);
    chk("R3", "async acc clear", 16'(acc_o), 16'h0);
    c = 0;
  endtask

  task automatic t_imm();
    int c;
    hold_reset();
    poke(8'd0, enc(4'h0, 4'h0, 8'hFF));
    poke(8'd1, enc(4'h1, 4'h0, 8'h01));
    poke(8'd2, enc(4'h8, 4'h0, 8'h02));
    run(c);
    chk("R4", "255+1", 16'(acc_o), 16'h00);
    chk("R6", "zero after wrap", 16'(zero_o), 16'h1);
    chk("R2", "cycles 3 instr", 16'(c), 16'd9);
    hold_reset();
    poke(8'd0, enc(4'h0, 4'hF, 8'hF6));
    poke(8'd1, enc(4'h1, 4'h7, 8'hFF));
    poke(8'd2, enc(4'h2, 4'h0, 8'h07));
    poke(8'd3, enc(4'h3, 4'h3, 8'h0F));
    poke(8'd4, enc(4'h0, 4'h0, 8'h03));
    poke(8'd5, enc(4'h2, 4'h0, 8'h07));
    poke(8'd6, enc(4'h8, 4'h0, 8'h06));
    run(c);
    chk("R4", "3-7 wrap", 16'(acc_o), 16'h00FC);
    chk("R2", "cycles 7 instr", 16'(c), 16'd21);
    hold_reset();
    poke(8'd0, enc(4'h0, 4'hF, 8'hF6));
    poke(8'd1, enc(4'h1, 4'h7, 8'hFF));
    poke(8'd2, enc(4'h8, 4'h0, 8'h02));
    run(c);
    chk("R1", "246+255 with bits 11:8 set", 16'(acc_o), 16'd245);
    hold_reset();
    poke(8'd0, enc(4'h0, 4'h0, 8'hF5));
    poke(8'd1, enc(4'h2, 4'h0, 8'h07));
    poke(8'd2, enc(4'h3, 4'h0, 8'h0F));
    poke(8'd3, enc(4'h8, 4'h0, 8'h03));
    run(c);
    chk("R4", "(245-7)&15", 16'(acc_o), 16'h000E);
    chk("R6", "zero clear", 16'(zero_o), 16'h0);
  endtask

  task automatic t_mem();
    int c;
    hold_reset();
    poke(8'h80, 16'hAB05);
    poke(8'h81, 16'h00FE);
    poke(8'h82, 16'h7703);
    poke(8'd0, enc(4'h4, 4'h0, 8'h80));
    poke(8'd1, enc(4'h6, 4'h0, 8'h81));
    poke(8'd2, enc(4'h7, 4'h0, 8'h82));
    poke(8'd3, enc(4'h8, 4'h0, 8'h03));
    run(c);
    chk("R5", "load/addm/subm", 16'(acc_o), 16'h0);
    chk("R6", "zero after subm", 16'(zero_o), 16'h1);
    hold_reset();
    poke(8'h83, 16'h1200);
    poke(8'd0, enc(4'h0, 4'h0, 8'h09));
    poke(8'd1, enc(4'h4, 4'h0, 8'h83));
    poke(8'd2, enc(4'h8, 4'h0, 8'h02));
    run(c);
    chk("R6", "zero after load of 0", 16'(zero_o), 16'h1);
    hold_reset();
    poke(8'd0, enc(4'h0, 4'h0, 8'h00));
    poke(8'd1, enc(4'h8, 4'h0, 8'h01));
    run(c);
    chk("R6", "zero after move 0", 16'(zero_o), 16'h1);
  endtask

  task automatic t_store();
    int c;
    hold_reset();
    fill(16'hFFFF);
    poke(8'd0, enc(4'h0, 4'h0, 8'd20));
    poke(8'd1, enc(4'h5, 4'hA, 8'h40));
    poke(8'd2, enc(4'hC, 4'h8, 8'h41));
    poke(8'd3, enc(4'h8, 4'h0, 8'h03));
    run(c);
    chk("R7", "plain store word", mem[8'h40], 16'h0014);
    chk("R8", "nibble store word", mem[8'h41], 16'h8014);
    chk("R7", "neighbour untouched", mem[8'h42], 16'hFFFF);
    chk("R7", "acc after stores", 16'(acc_o), 16'd20);
  endtask

  task automatic t_jumps();
    int c;
    hold_reset();
    poke(8'd0,  enc(4'h0, 4'h0, 8'h00));
    poke(8'd1,  enc(4'h9, 4'h0, 8'd3));
    poke(8'd2,  enc(4'h0, 4'h0, 8'hFF));
    poke(8'd3,  enc(4'h1, 4'h0, 8'h01));
    poke(8'd4,  enc(4'hA, 4'h0, 8'd6));
    poke(8'd5,  enc(4'h0, 4'h0, 8'hFF));
    poke(8'd6,  enc(4'h9, 4'h0, 8'd9));
    poke(8'd7,  enc(4'h3, 4'h0, 8'h00));
    poke(8'd8,  enc(4'hA, 4'h0, 8'd11));
    poke(8'd9,  enc(4'h1, 4'h0, 8'h05));
    poke(8'd10, enc(4'h8, 4'h0, 8'd12));
    poke(8'd11, enc(4'h0, 4'h0, 8'hFF));
    poke(8'd12, enc(4'h8, 4'h0, 8'd12));
    run(c);
    chk("R9", "acc after jump chain", 16'(acc_o), 16'h05);
    chk("R9", "pc at end", 16'(pc_o), 16'd12);
    chk("R9", "instr path cycles", 16'(c), 16'd30);
  endtask

  task automatic t_reserved();
    int c;
    hold_reset();
    poke(8'd0, enc(4'h0, 4'h0, 8'h07));
    poke(8'd1, enc(4'hB, 4'h0, 8'd5));
    poke(8'd2, enc(4'hD, 4'h0, 8'd5));
    poke(8'd3, enc(4'hE, 4'h0, 8'd5));
    poke(8'd4, enc(4'hF, 4'h0, 8'd5));
    poke(8'd5, enc(4'h1, 4'h0, 8'h01));
    poke(8'd6, enc(4'h8, 4'h0, 8'd6));
    run(c);
    chk("R10", "acc after no-ops", 16'(acc_o), 16'h08);
    chk("R10", "cycles through no-ops", 16'(c), 16'd21);
    chk("R10", "pc", 16'(pc_o), 16'd6);
  endtask

  task automatic t_halt();
    int c, writes;
    hold_reset();
    poke(8'd0, enc(4'h0, 4'h0, 8'h01));
    poke(8'd1, enc(4'h9, 4'h0, 8'd1));
    poke(8'd2, enc(4'h0, 4'h0, 8'h00));
    poke(8'd3, enc(4'hA, 4'h0, 8'd3));
    poke(8'd4, enc(4'h9, 4'h0, 8'd4));
    chk("R11", "halt low before run", 16'(halt_o), 16'h0);
    run(c);
    chk("R11", "halt cycle", 16'(c), 16'd15);
    chk("R11", "halt pc", 16'(pc_o), 16'd4);
    writes = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_we) writes++;
    end
    chk("R11", "halt sticky", 16'(halt_o), 16'h1);
    chk("R11", "pc frozen", 16'(pc_o), 16'd4);
    chk("R11", "acc frozen", 16'(acc_o), 16'h0);
    chk("R11", "no writes halted", 16'(writes), 16'h0);
  endtask

  initial begin
    t_reset();
    t_imm();
    t_mem();
    t_store();
    t_jumps();
    t_reserved();
    t_halt();
    summary();
    $finish;
  end
endmodule